// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Memory Page-Load Front End

This block sits on the device side of a byte-wide nonvolatile memory with a 17-bit address and an 8-bit data bus. The active-low chip-select, write-strobe and output-enable lines arrive already synchronised to a fast system clock. The block turns them into byte loads. A load is taken only when chip-select and write-strobe overlap while output-enable is high. The block rejects overlaps that are too short to be real writes. It latches the address at the start of each overlap and the data at its end, then stores the byte in a page buffer that holds up to 256 entries.

A page has no fixed length. The first accepted byte fixes the upper address bits, which form the page number. Each later byte with the same page number fills the entry picked by the low eight address bits. A byte that names another page is dropped, and a sticky error output is raised. A window timer restarts at each new qualified write. When it runs out, the page is handed to a programming stage, modelled as a busy counter of fixed length. While that stage runs, any write on the pins is ignored. When it ends, the page buffer is emptied. The programming sequencer reads the page through an index port that returns the data byte and a filled flag.

Controller states: `ST_IDLE` (no page open), `ST_LOAD` (page open, window timer running) and `ST_PROG` (programming busy). Transitions: `ST_IDLE -> ST_LOAD` on the first accepted byte; `ST_LOAD -> ST_PROG` when the window expires; `ST_PROG -> ST_IDLE` when the busy count completes.

Top module: `eeprom_page_loader`

## Requirements
- R1: After reset, `busy`, `loading` and `page_err` are low and every page entry reads back with `rd_filled` low.
- R2: A byte is loaded only from an interval in which `ce_n` and `we_n` are both low and `oe_n` is high. Holding `oe_n` low, `ce_n` high or `we_n` high during strobe activity loads nothing and leaves `loading` low.
- R3: The address is the value on `addr` in the first cycle of the overlap, which is set by whichever of `ce_n`/`we_n` falls last. The data is the value on `din` in the last cycle of the overlap, before whichever of the two rises first.
- R4: An overlap shorter than `MIN_WE_LOW` clock cycles is discarded. An overlap of exactly `MIN_WE_LOW` cycles is accepted.
- R5: The first accepted byte of a page sets `prog_page` to `addr[16:8]`. Every accepted byte of the page is stored at entry `addr[7:0]`, where `rd_idx` returns it on `rd_data` with `rd_filled` high. Entries never written keep `rd_filled` low.
- R6: While a page is open, a byte whose `addr[16:8]` differs from `prog_page` is not stored. It sets `page_err`, which stays high until reset.
- R7: Bytes whose gaps stay below the timeout all join one page. `busy` rises on the (`TIMEOUT_CYC`+1)-th rising clock edge after the last overlap ends, and this holds for a page of a single byte too.
- R8: `busy` stays high for exactly `PROG_CYC` clock cycles. After that, `loading` is low and every entry has `rd_filled` low.
- R9: Strobe activity while `busy` is high stores nothing, raises no error and does not change the length of the busy period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low, synchronised |
| we_n | input | 1 | Write strobe, active low, synchronised |
| oe_n | input | 1 | Output enable, active low, synchronised |
| addr | input | 17 | Byte address; upper 9 bits page, lower 8 bits entry |
| din | input | 8 | Write data |
| rd_idx | input | 8 | Page entry selected for the programming sequencer |
| busy | output | 1 | Programming cycle in progress |
| loading | output | 1 | A page is open and collecting bytes |
| page_err | output | 1 | Sticky flag: a byte for a foreign page was dropped |
| prog_page | output | 9 | Locked page number of the current page |
| rd_data | output | 8 | Data stored at `rd_idx` |
| rd_filled | output | 1 | Entry at `rd_idx` has been written in this page |

## Verification
An accepted byte becomes visible on `loading`, `rd_data` and `page_err` two rising edges after the overlap ends: one edge for the decoder's load pulse and one for the controller. The bench therefore samples on the second falling edge or later. `busy` is checked low on the `TIMEOUT_CYC`-th falling edge after the last release and high on the next one. The busy period is then counted one falling edge at a time and must total exactly `PROG_CYC` cycles, including a run that has a stray write inside it. Every output is read at falling edges after the combinational read port has settled, so no sample lands on the edge that updates the value.

// File: rtl/eepl_pkg.sv
package eepl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } ld_state_e;

endpackage

// File: rtl/eepl_strobe_decode.sv
module eepl_strobe_decode #(
    parameter int ADDR_W  = 17,
    parameter int DATA_W  = 8,
    parameter int MIN_LOW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              qual_o,
    output logic              held_o,
    output logic              load_vld_o,
    output logic [ADDR_W-1:0] load_addr_o,
    output logic [DATA_W-1:0] load_data_o
);

    localparam int CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] LOW_FULL = CW'(MIN_LOW);
    localparam logic [CW-1:0] LOW_LAST = CW'(MIN_LOW - 1);

    logic              act;
    logic              act_q;
    logic [CW-1:0]     low_cnt;
    logic [ADDR_W-1:0] addr_lat;
    logic [DATA_W-1:0] data_lat;
    logic              qual_q;
    logic              load_q;

    // write overlap: both strobes low, output driver off
    assign act = !ce_n && !we_n && oe_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q    <= 1'b0;
            low_cnt  <= '0;
            addr_lat <= '0;
            data_lat <= '0;
            qual_q   <= 1'b0;
            load_q   <= 1'b0;
        end else begin
            act_q <= act;
            if (act) begin
                if (!act_q) begin
                    addr_lat <= addr;
                end
                data_lat <= din;
                if (low_cnt != LOW_FULL) begin
                    low_cnt <= low_cnt + 1'b1;
                end
            end else begin
                low_cnt <= '0;
            end
            qual_q <= act && (low_cnt == LOW_LAST);
            load_q <= !act && act_q && oe_n && (low_cnt == LOW_FULL);
        end
    end

    assign qual_o      = qual_q;
    assign held_o      = (low_cnt == LOW_FULL);
    assign load_vld_o  = load_q;
    assign load_addr_o = addr_lat;
    assign load_data_o = data_lat;

    AST_LOAD_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        load_q |-> $past(held_o)); // R4
    AST_LOAD_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        load_q |-> $past(oe_n)); // R2
    AST_QUAL_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        qual_q |=> !qual_q); // R4

endmodule

// File: rtl/eepl_page_buffer.sv
module eepl_page_buffer #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 256
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     clr,
    input  logic                     hold,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     rd_filled
);

    localparam int IW = $clog2(DEPTH);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DEPTH-1:0]  fill_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_fill
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fill_q[g] <= 1'b0;
            end else if (clr) begin
                fill_q[g] <= 1'b0;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                fill_q[g] <= 1'b1;
            end
        end
    end

    assign rd_data   = mem_q[rd_idx];
    assign rd_filled = fill_q[rd_idx];

    AST_FILL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && $past(hold)) |-> $stable(fill_q)); // R9
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (fill_q == '0)); // R8

endmodule

// File: rtl/eepl_load_fsm.sv
module eepl_load_fsm
    import eepl_pkg::*;
#(
    parameter int PG_W        = 9,
    parameter int TIMEOUT_CYC = 25000,
    parameter int PROG_CYC    = 1250000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            qual,
    input  logic            held,
    input  logic            load_vld,
    input  logic [PG_W-1:0] load_page,
    output logic            wr_en,
    output logic            clr,
    output logic            busy,
    output logic            loading,
    output logic            page_err,
    output logic [PG_W-1:0] page_q
);

    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam int PW = $clog2(PROG_CYC + 1);
    localparam logic [TW-1:0] WIN_LAST  = TW'(TIMEOUT_CYC - 1);
    localparam logic [PW-1:0] PROG_LAST = PW'(PROG_CYC - 1);

    ld_state_e state_q, state_d;
    logic [TW-1:0] win_cnt;
    logic [PW-1:0] prog_cnt;
    logic          err_q;
    logic          page_hit;
    logic          expire;
    logic          prog_end;
    logic          bad_load;

    assign page_hit = (load_page == page_q);
    assign expire   = (state_q == ST_LOAD) && !held && !qual && (win_cnt == WIN_LAST);
    assign prog_end = (state_q == ST_PROG) && (prog_cnt == PROG_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load_vld) state_d = ST_LOAD;
            ST_LOAD: if (expire)   state_d = ST_PROG;
            ST_PROG: if (prog_end) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // window timer, programming counter, page lock, error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt  <= '0;
            prog_cnt <= '0;
            page_q   <= '0;
            err_q    <= 1'b0;
        end else begin
            if (qual) begin
                win_cnt <= '0;
            end else if (!held && (state_q != ST_PROG)) begin
                win_cnt <= win_cnt + 1'b1;
            end
            if (state_q == ST_PROG) begin
                prog_cnt <= prog_cnt + 1'b1;
            end else begin
                prog_cnt <= '0;
            end
            if ((state_q == ST_IDLE) && load_vld) begin
                page_q <= load_page;
            end
            if (bad_load) begin
                err_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        wr_en    = 1'b0;
        bad_load = 1'b0;
        busy     = 1'b0;
        loading  = 1'b0;
        clr      = 1'b0;
        unique case (state_q)
            ST_IDLE: wr_en = load_vld;
            ST_LOAD: begin
                loading  = 1'b1;
                wr_en    = load_vld && page_hit;
                bad_load = load_vld && !page_hit;
            end
            ST_PROG: begin
                busy = 1'b1;
                clr  = prog_end;
            end
            default: ;
        endcase
    end

    assign page_err = err_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        page_err |=> page_err); // R6
    AST_PROG_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(loading)); // R7
    AST_PROG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (prog_cnt <= PROG_LAST)); // R8
    AST_PAGE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (loading && $past(loading)) |-> $stable(page_q)); // R5

endmodule

// File: rtl/eeprom_page_loader.sv
module eeprom_page_loader #(
    parameter int ADDR_W      = 17,
    parameter int DATA_W      = 8,
    parameter int PAGE_BYTES  = 256,
    parameter int MIN_WE_LOW  = 3,
    parameter int TIMEOUT_CYC = 25000,
    parameter int PROG_CYC    = 1250000
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   ce_n,
    input  logic                                   we_n,
    input  logic                                   oe_n,
    input  logic [ADDR_W-1:0]                      addr,
    input  logic [DATA_W-1:0]                      din,
    input  logic [$clog2(PAGE_BYTES)-1:0]          rd_idx,
    output logic                                   busy,
    output logic                                   loading,
    output logic                                   page_err,
    output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]   prog_page,
    output logic [DATA_W-1:0]                      rd_data,
    output logic                                   rd_filled
);

    localparam int IDX_W = $clog2(PAGE_BYTES);
    localparam int PG_W  = ADDR_W - IDX_W;

    logic              qual;
    logic              held;
    logic              load_vld;
    logic [ADDR_W-1:0] load_addr;
    logic [DATA_W-1:0] load_data;
    logic              wr_en;
    logic              clr;

    eepl_strobe_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .MIN_LOW(MIN_WE_LOW)
    ) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n       (ce_n),
        .we_n       (we_n),
        .oe_n       (oe_n),
        .addr       (addr),
        .din        (din),
        .qual_o     (qual),
        .held_o     (held),
        .load_vld_o (load_vld),
        .load_addr_o(load_addr),
        .load_data_o(load_data)
    );

    eepl_load_fsm #(
        .PG_W       (PG_W),
        .TIMEOUT_CYC(TIMEOUT_CYC),
        .PROG_CYC   (PROG_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .qual     (qual),
        .held     (held),
        .load_vld (load_vld),
        .load_page(load_addr[ADDR_W-1:IDX_W]),
        .wr_en    (wr_en),
        .clr      (clr),
        .busy     (busy),
        .loading  (loading),
        .page_err (page_err),
        .page_q   (prog_page)
    );

    eepl_page_buffer #(
        .DATA_W(DATA_W),
        .DEPTH (PAGE_BYTES)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (load_addr[IDX_W-1:0]),
        .wr_data  (load_data),
        .clr      (clr),
        .hold     (busy),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .rd_filled(rd_filled)
    );

endmodule

// File: tb/eeprom_page_loader_bench.sv
module eeprom_page_loader_bench;

    localparam int TMO  = 40;
    localparam int PROG = 60;
    localparam int MINL = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic        oe_n = 1'b1;
    logic [16:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  rd_idx = '0;
    logic        busy, loading, page_err, rd_filled;
    logic [8:0]  prog_page;
    logic [7:0]  rd_data;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    eeprom_page_loader #(
        .MIN_WE_LOW (MINL),
        .TIMEOUT_CYC(TMO),
        .PROG_CYC   (PROG)
    ) u_eeprom_page_loader (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .rd_idx(rd_idx), .busy(busy), .loading(loading),
        .page_err(page_err), .prog_page(prog_page), .rd_data(rd_data),
        .rd_filled(rd_filled)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] idx, output logic [7:0] d, output logic f);
        rd_idx = idx;
        #1;
        d = rd_data;
        f = rd_filled;
    endtask

    task automatic wr_byte(input logic [16:0] a, input logic [7:0] d, input int len, input int gap);
        @(negedge clk);
        addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
        repeat (len) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        repeat (gap) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int t = 0; t < 2000 && (busy || loading); t++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d; logic f;
        chk("R1 busy", busy, 0);
        chk("R1 loading", loading, 0);
        chk("R1 page_err", page_err, 0);
        rd(8'h00, d, f); chk("R1 filled[00]", f, 0);
        rd(8'hFF, d, f); chk("R1 filled[FF]", f, 0);
    endtask

    task automatic t_blocked();
        @(negedge clk);
        addr = 17'h00123; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        repeat (6) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2 oe low blocks", loading, 0);
        we_n = 1'b0;
        repeat (6) @(negedge clk);
        we_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2 ce high blocks", loading, 0);
        ce_n = 1'b0;
        repeat (6) @(negedge clk);
        ce_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2 we high blocks", loading, 0);
    endtask

    task automatic t_glitch();
        logic [7:0] d; logic f;
        wr_byte({9'h005, 8'h10}, 8'hA5, MINL - 1, 4);
        chk("R4 short overlap rejected", loading, 0);
        wr_byte({9'h005, 8'h10}, 8'h3C, MINL, 3);
        chk("R4 minimum overlap accepted", loading, 1);
        rd(8'h10, d, f);
        chk("R4 data", d, 8'h3C);
        chk("R4 filled", f, 1);
        wait_idle();
    endtask

    task automatic t_timing();
        logic [7:0] d; logic f;
        wr_byte({9'h0C7, 8'h2B}, 8'h5E, 4, 0);
        repeat (TMO) @(negedge clk);
        chk("R7 busy low before expiry", busy, 0);
        chk("R7 loading before expiry", loading, 1);
        @(negedge clk);
        chk("R7 busy at expiry", busy, 1);
        chk("R5 prog_page", prog_page, 9'h0C7);
        rd(8'h2B, d, f);
        chk("R5 single byte data", d, 8'h5E);
        chk("R5 single byte filled", f, 1);
        repeat (PROG - 1) @(negedge clk);
        chk("R8 busy before end", busy, 1);
        @(negedge clk);
        chk("R8 busy cleared", busy, 0);
        chk("R8 loading low", loading, 0);
        rd(8'h2B, d, f);
        chk("R8 filled cleared", f, 0);
    endtask

    task automatic t_page();
        logic [7:0] d; logic f;
        wr_byte({9'h1A3, 8'h00}, 8'h11, 4, 25);
        wr_byte({9'h1A3, 8'h01}, 8'h22, 4, 25);
        chk("R7 still loading within window", loading, 1);
        chk("R7 not busy within window", busy, 0);
        wr_byte({9'h1A3, 8'hFF}, 8'h33, 4, 0);
        for (int t = 0; t < 200 && !busy; t++) @(negedge clk);
        chk("R7 page programs", busy, 1);
        chk("R5 locked page", prog_page, 9'h1A3);
        rd(8'h00, d, f); chk("R5 entry 00", {f, d}, {1'b1, 8'h11});
        rd(8'h01, d, f); chk("R5 entry 01", {f, d}, {1'b1, 8'h22});
        rd(8'hFF, d, f); chk("R5 entry FF", {f, d}, {1'b1, 8'h33});
        rd(8'h02, d, f); chk("R5 entry 02 empty", f, 0);
        wait_idle();
    endtask

    task automatic t_busy_ignore();
        logic [7:0] d; logic f;
        int k;
        wr_byte({9'h004, 8'h03}, 8'h77, 4, 0);
        for (int t = 0; t < 200 && !busy; t++) @(negedge clk);
        wr_byte({9'h004, 8'h09}, 8'h88, 4, 0);
        k = 4 + 2;
        repeat (3) @(negedge clk);
        k += 3;
        rd(8'h09, d, f);
        chk("R9 write during busy not stored", f, 0);
        chk("R9 no error from busy write", page_err, 0);
        while (busy && k < 1000) begin
            @(negedge clk);
            if (busy) k++;
        end
        chk("R9 busy length unchanged", k, PROG);
        chk("R9 no page opened", loading, 0);
    endtask

    task automatic t_capture();
        logic [7:0] d; logic f;
        @(negedge clk);
        addr = {9'h0EE, 8'h20}; din = 8'h00; we_n = 1'b0; ce_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b0; addr = {9'h0EE, 8'h40};
        @(negedge clk);
        addr = {9'h0EE, 8'h41}; din = 8'h11;
        @(negedge clk);
        din = 8'h99;
        @(negedge clk);
        ce_n = 1'b1; din = 8'h55;
        @(negedge clk);
        we_n = 1'b1;
        repeat (3) @(negedge clk);
        rd(8'h40, d, f); chk("R3 address at last fall", {f, d}, {1'b1, 8'h99});
        rd(8'h41, d, f); chk("R3 later address unused", f, 0);
        rd(8'h20, d, f); chk("R3 earlier address unused", f, 0);
        wait_idle();
    endtask

    task automatic t_mismatch();
        logic [7:0] d; logic f;
        chk("R6 error clear before", page_err, 0);
        wr_byte({9'h002, 8'h00}, 8'h44, 4, 5);
        wr_byte({9'h003, 8'h07}, 8'h66, 4, 3);
        chk("R6 mismatch flagged", page_err, 1);
        rd(8'h07, d, f); chk("R6 mismatch not stored", f, 0);
        chk("R6 page kept", prog_page, 9'h002);
        wait_idle();
        chk("R6 flag sticky", page_err, 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_blocked();
        t_glitch();
        t_timing();
        t_page();
        t_busy_ignore();
        t_capture();
        t_mismatch();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule